// File: doc/BRIEF.md
# Serial Transmit Data Pin Driver with Tristate Release

This block owns the transmit data pin of a programmable serial port that sends words most significant bit first, and decides when that pin is driven and when it floats. A parallel word and a start strobe are accepted. The word is then shifted out one bit per serial clock period. A separate output-enable tells the pad when to drive. The port can be the clock master, with edges paced by a clock-enable input, or the clock slave, with edges taken from an external serial clock after synchronisation. It can also be the frame master, which starts on the strobe and drives a frame pin, or the frame slave, which holds the word until an external frame signal turns active.

There are three ways to release the pin. With tristating off, the pin is never released. With tristating on, the pin floats one serial clock edge after the edge that launches the last bit. A late-release option adds one more edge before the release. This option takes effect only in programmable-serial mode when the port is a frame slave. As clock master, the block counts that extra edge internally even though it is never shown on the clock pin. As clock slave, it waits for the external clock to supply the edge.

Top module: `sptt_tx_tristate`

## Requirements
- R1: During and right after reset, `txd` is 0, `busy` is 0, `sclk_out` sits at `cfg_mode[1]`, `frm_out` is inactive, and `txd_oe` is 0 when `cfg_tte` is 1.
- R2: The word length is `cfg_wlen` bits, clamped to the range 4..32. The bits are sent from bit `len-1` down to bit 0.
- R3: `cfg_mode[1]` sets the idle clock level. `cfg_mode[0]`=0 drives the first bit when the word starts and `cfg_mode[0]`=1 drives it on the first clock edge. Each later bit is driven two edges after the one before it.
- R4: As clock master, `sclk_out` makes exactly 2×len transitions per word and returns to its idle level. As clock slave, it rests at the idle level.
- R5: With `cfg_tte`=1, `txd_oe` rises together with the launch of the first bit.
- R6: With `cfg_tte`=1 and late release not in effect, `txd_oe` falls on the edge right after the launch edge of the last bit.
- R7: Late release moves the fall of `txd_oe` one edge later. It is in effect only when `cfg_late`, `cfg_psp` and `cfg_frm_slave` are all 1, and otherwise has no effect.
- R8: As clock master with `cfg_mode[0]`=1, the late-release edge is counted internally from `bit_tick` and does not toggle `sclk_out`.
- R9: As clock slave under late release, `txd_oe` stays 1 until the external clock supplies the extra edge, however long that takes.
- R10: With `cfg_tte`=0, `txd_oe` is constantly 1 and `txd` keeps the last bit sent between words.
- R11: As frame master, `frm_out` is active from the start of the word until the sampling edge of the last bit. The active level is `cfg_frm_pol` (1 means high).
- R12: As frame slave, `tx_start` only stores the word. Sending begins when `frm_in` turns to the active level given by `cfg_frm_pol`, and a frame with no stored word starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_tte | input | 1 | Enable tristating of the data pin between words |
| cfg_late | input | 1 | Request late release |
| cfg_psp | input | 1 | Programmable-serial frame format selected |
| cfg_frm_slave | input | 1 | 1: frame comes from `frm_in`; 0: block drives `frm_out` |
| cfg_clk_slave | input | 1 | 1: edges come from `sclk_in`; 0: edges come from `bit_tick` |
| cfg_mode | input | 2 | Bit 1 idle clock level, bit 0 launch phase |
| cfg_frm_pol | input | 1 | Frame active level |
| cfg_wlen | input | 6 | Word length in bits |
| tx_word | input | 32 | Parallel word to send |
| tx_start | input | 1 | Single-cycle strobe that loads `tx_word` |
| bit_tick | input | 1 | Clock-master edge enable, one pulse per serial clock edge |
| sclk_in | input | 1 | External serial clock in clock-slave mode |
| frm_in | input | 1 | External frame in frame-slave mode |
| sclk_out | output | 1 | Generated serial clock |
| frm_out | output | 1 | Generated frame |
| txd | output | 1 | Serial data |
| txd_oe | output | 1 | Output enable for the data pad |
| busy | output | 1 | A word is in progress |

## Verification
The bound checker checks these on every cycle:
- `txd_oe` is forced to 1 while tristating is off.
- `txd` and a rising `txd_oe` change only on a counted edge or a word start.
- `txd_oe` falls only on a counted edge.
- The generated clock sits at its idle level whenever no word is in progress.

Some behaviour can only be shown by the bench's scenarios. These are the exact edge index at which the pin is released in each mode, the hidden trailing edge counted as clock master, the indefinite hold as clock slave until the extra edge comes, the clamping of the word length, and the rule that late release has no effect outside the frame-slave programmable-serial case.

// File: rtl/sptt_pkg.sv
// Shared types for the serial transmit tristate controller.
package sptt_pkg;

    // Sequencer state: idle between words, run while a word is in flight.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

endpackage

// File: rtl/sptt_cfg_gate.sv
// Configuration qualifier.
// Passes the late-release request only when the port is in programmable
// serial format and is a frame slave, and clamps the word length into
// [MIN_W, MAX_W]. Purely combinational; assumes configuration is static
// while a word is in flight.
module sptt_cfg_gate #(
    parameter int MAX_W = 32,
    parameter int MIN_W = 4,
    localparam int LW   = $clog2(MAX_W + 1)
) (
    input  logic          late_req,
    input  logic          psp_sel,
    input  logic          frm_slave,
    input  logic [LW-1:0] wlen_req,
    output logic          late_eff,
    output logic [LW-1:0] wlen_eff
);

    // Late release is only legal for a frame slave in programmable serial format.
    always_comb late_eff = late_req & psp_sel & frm_slave;

    // Clamp the requested word length into the supported range.
    always_comb begin
        if (wlen_req < LW'(MIN_W)) begin
            wlen_eff = LW'(MIN_W);
        end else if (wlen_req > LW'(MAX_W)) begin
            wlen_eff = LW'(MAX_W);
        end else begin
            wlen_eff = wlen_req;
        end
    end

endmodule

// File: rtl/sptt_sync.sv
// Input synchroniser with history.
// Moves an asynchronous pin through STAGES flops and also gives the value
// one cycle older, so a caller can detect transitions. Assumes STAGES >= 2.
module sptt_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic q,
    output logic q_prev
);

    logic [STAGES:0] chain;

    // Shift the pin value along the chain each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= {(STAGES + 1){RST_VAL}};
        end else begin
            chain <= {chain[STAGES-1:0], din};
        end
    end

    assign q      = chain[STAGES-1];
    assign q_prev = chain[STAGES];

endmodule

// File: rtl/sptt_edge_src.sv
// Serial clock edge source.
// Clock master: each bit_tick while running is one serial clock edge, and
// sclk_out toggles on it while the sequencer marks the edge as visible.
// Clock slave: each transition of the synchronised external clock while
// running is one edge, and sclk_out rests at the idle level.
module sptt_edge_src (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_slave,
    input  logic cpol,
    input  logic tick,
    input  logic sin_q,
    input  logic sin_prev,
    input  logic run,
    input  logic vis,
    output logic edge_stb,
    output logic sclk_q
);

    // Select where serial clock edges come from.
    always_comb edge_stb = run & (clk_slave ? (sin_q ^ sin_prev) : tick);

    // Generated clock: idle level between words, toggles on visible edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= cpol;
        end else if (!run || clk_slave) begin
            sclk_q <= cpol;
        end else if (edge_stb && vis) begin
            sclk_q <= ~sclk_q;
        end
    end

endmodule

// File: rtl/sptt_frame_ctl.sv
// Frame controller.
// Holds the word loaded by tx_start until it may start. A frame master
// starts as soon as the sequencer is idle. A frame slave waits for frm_in
// to become active (polarity per pol). Also forms the frame output pin.
module sptt_frame_ctl #(
    parameter int MAX_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frm_slave,
    input  logic             pol,
    input  logic             tx_start,
    input  logic [MAX_W-1:0] tx_word,
    input  logic             fin_q,
    input  logic             fin_prev,
    input  logic             run,
    input  logic             frm_act,
    output logic             go,
    output logic [MAX_W-1:0] go_word,
    output logic             frm_out
);

    logic pend;
    logic act_now;
    logic act_old;
    logic frame_rise;

    // Map the synchronised frame pin to an "active" flag and find its start.
    always_comb begin
        act_now    = pol ? fin_q    : ~fin_q;
        act_old    = pol ? fin_prev : ~fin_prev;
        frame_rise = act_now & ~act_old;
    end

    // Launch the held word when the frame rules allow it.
    always_comb go = pend & ~run & (frm_slave ? frame_rise : 1'b1);

    // Hold the word from its strobe until it is launched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend    <= 1'b0;
            go_word <= '0;
        end else if (tx_start) begin
            pend    <= 1'b1;
            go_word <= tx_word;
        end else if (go) begin
            pend    <= 1'b0;
        end
    end

    // Frame pin: inactive level when slave, active while the word runs when master.
    always_comb frm_out = (!frm_slave && frm_act) ? pol : ~pol;

endmodule

// File: rtl/sptt_shift_core.sv
// Shift sequencer and tristate timing.
// Counts serial clock edges as positions of the word: position 0 launches
// the MSB, even positions up to 2N-2 launch bits, 2N-1 samples the LSB.
// Phase 0 performs position 0 at the word start; phase 1 on the first edge.
// Output enable rises at position 0 and falls at 2N-1 (normal) or 2N
// (late). The word ends at the later of the release position and the last
// position visible on the clock pin. Assumes go is only pulsed when idle.
module sptt_shift_core
    import sptt_pkg::*;
#(
    parameter int MAX_W = 32,
    localparam int LW   = $clog2(MAX_W + 1),
    localparam int PW   = $clog2(2 * MAX_W + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [MAX_W-1:0] go_word,
    input  logic [LW-1:0]    go_len,
    input  logic             go_cpha,
    input  logic             go_late,
    input  logic             edge_stb,
    output logic             run,
    output logic             vis,
    output logic             txd_q,
    output logic             oe_q,
    output logic             frm_act
);

    run_state_e       st;
    logic [MAX_W-1:0] shreg;
    logic [MAX_W-1:0] aligned;
    logic [LW-1:0]    n_q;
    logic             cpha_q;
    logic             late_q;
    logic [PW-1:0]    nxt;
    logic [PW-1:0]    two_n;
    logic [PW-1:0]    lsb_pos;
    logic [PW-1:0]    rel_pos;
    logic [PW-1:0]    last_vis;
    logic [PW-1:0]    end_pos;
    logic             launch;

    // Key positions of the current word, in edge units.
    always_comb begin
        two_n    = PW'({n_q, 1'b0});
        lsb_pos  = two_n - PW'(2);
        rel_pos  = late_q ? two_n : two_n - PW'(1);
        last_vis = cpha_q ? two_n - PW'(1) : two_n;
        end_pos  = (rel_pos > last_vis) ? rel_pos : last_vis;
    end

    // Left-align the incoming word so its MSB sits at the top of the register.
    always_comb aligned = go_word << (LW'(MAX_W) - go_len);

    // Status toward the edge source and the launch decision for this edge.
    always_comb begin
        run    = (st == ST_RUN);
        vis    = run && (nxt <= last_vis);
        launch = run && edge_stb && !nxt[0] && (nxt <= lsb_pos);
    end

    // Sequencer: load on go, then act on every counted edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            shreg   <= '0;
            n_q     <= '0;
            cpha_q  <= 1'b0;
            late_q  <= 1'b0;
            nxt     <= '0;
            txd_q   <= 1'b0;
            oe_q    <= 1'b0;
            frm_act <= 1'b0;
        end else if (go && !run) begin
            st      <= ST_RUN;
            n_q     <= go_len;
            cpha_q  <= go_cpha;
            late_q  <= go_late;
            frm_act <= 1'b1;
            if (go_cpha) begin
                shreg <= aligned;
                nxt   <= '0;
            end else begin
                txd_q <= aligned[MAX_W-1];
                shreg <= aligned << 1;
                oe_q  <= 1'b1;
                nxt   <= PW'(1);
            end
        end else if (run && edge_stb) begin
            nxt <= nxt + PW'(1);
            if (launch) begin
                txd_q <= shreg[MAX_W-1];
                shreg <= shreg << 1;
            end
            if (launch && nxt == '0) begin
                oe_q <= 1'b1;
            end
            if (nxt == rel_pos) begin
                oe_q <= 1'b0;
            end
            if (nxt == two_n - PW'(1)) begin
                frm_act <= 1'b0;
            end
            if (nxt == end_pos) begin
                st <= ST_IDLE;
            end
        end
    end

endmodule

// File: rtl/sptt_tx_tristate.sv
// Serial port transmit data pin controller (top).
// Connects configuration gating, pin synchronisers, frame control, the
// edge source and the shift sequencer. Drives txd with a separate output
// enable. Assumes configuration changes only while busy is low.
module sptt_tx_tristate #(
    parameter int  MAX_W       = 32,
    parameter int  MIN_W       = 4,
    parameter int  SYNC_STAGES = 2,
    localparam int LW          = $clog2(MAX_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_tte,
    input  logic             cfg_late,
    input  logic             cfg_psp,
    input  logic             cfg_frm_slave,
    input  logic             cfg_clk_slave,
    input  logic [1:0]       cfg_mode,
    input  logic             cfg_frm_pol,
    input  logic [LW-1:0]    cfg_wlen,
    input  logic [MAX_W-1:0] tx_word,
    input  logic             tx_start,
    input  logic             bit_tick,
    input  logic             sclk_in,
    input  logic             frm_in,
    output logic             sclk_out,
    output logic             frm_out,
    output logic             txd,
    output logic             txd_oe,
    output logic             busy
);

    logic             late_eff;
    logic [LW-1:0]    wlen_eff;
    logic             sin_q;
    logic             sin_prev;
    logic             fin_q;
    logic             fin_prev;
    logic             go_stb;
    logic [MAX_W-1:0] go_word;
    logic             edge_stb;
    logic             run;
    logic             vis;
    logic             txd_q;
    logic             oe_q;
    logic             frm_act;

    sptt_cfg_gate #(.MAX_W(MAX_W), .MIN_W(MIN_W)) u_cfg (
        .late_req  (cfg_late),
        .psp_sel   (cfg_psp),
        .frm_slave (cfg_frm_slave),
        .wlen_req  (cfg_wlen),
        .late_eff  (late_eff),
        .wlen_eff  (wlen_eff)
    );

    sptt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sclk_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (sclk_in),
        .q      (sin_q),
        .q_prev (sin_prev)
    );

    sptt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_frm_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (frm_in),
        .q      (fin_q),
        .q_prev (fin_prev)
    );

    sptt_frame_ctl #(.MAX_W(MAX_W)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .frm_slave (cfg_frm_slave),
        .pol       (cfg_frm_pol),
        .tx_start  (tx_start),
        .tx_word   (tx_word),
        .fin_q     (fin_q),
        .fin_prev  (fin_prev),
        .run       (run),
        .frm_act   (frm_act),
        .go        (go_stb),
        .go_word   (go_word),
        .frm_out   (frm_out)
    );

    sptt_edge_src u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_slave (cfg_clk_slave),
        .cpol      (cfg_mode[1]),
        .tick      (bit_tick),
        .sin_q     (sin_q),
        .sin_prev  (sin_prev),
        .run       (run),
        .vis       (vis),
        .edge_stb  (edge_stb),
        .sclk_q    (sclk_out)
    );

    sptt_shift_core #(.MAX_W(MAX_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go_stb),
        .go_word  (go_word),
        .go_len   (wlen_eff),
        .go_cpha  (cfg_mode[0]),
        .go_late  (late_eff),
        .edge_stb (edge_stb),
        .run      (run),
        .vis      (vis),
        .txd_q    (txd_q),
        .oe_q     (oe_q),
        .frm_act  (frm_act)
    );

    // Pin outputs: enable forced on when tristating is disabled.
    always_comb begin
        txd    = txd_q;
        txd_oe = ~cfg_tte | oe_q;
        busy   = run;
    end

endmodule

// File: rtl/sptt_tx_tristate_chk.sv
// Protocol checker for the transmit tristate controller, bound to the top.
module sptt_tx_tristate_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_tte,
    input logic [1:0] cfg_mode,
    input logic       txd,
    input logic       txd_oe,
    input logic       sclk_out,
    input logic       busy,
    input logic       edge_stb,
    input logic       go_stb
);

    AST_OE_FORCED_ON: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_tte |-> txd_oe); // R10

    AST_TXD_MOVES_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (txd != $past(txd)) |-> $past(edge_stb || go_stb)); // R3

    AST_OE_RISE_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(txd_oe) && cfg_tte && $past(cfg_tte)) |-> $past(edge_stb || go_stb)); // R5

    AST_OE_FALL_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(txd_oe) && cfg_tte && $past(cfg_tte)) |-> $past(edge_stb)); // R9

    AST_SCLK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy) && $stable(cfg_mode)) |-> (sclk_out == cfg_mode[1])); // R4

endmodule

bind sptt_tx_tristate sptt_tx_tristate_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_tte  (cfg_tte),
    .cfg_mode (cfg_mode),
    .txd      (txd),
    .txd_oe   (txd_oe),
    .sclk_out (sclk_out),
    .busy     (busy),
    .edge_stb (edge_stb),
    .go_stb   (go_stb)
);

// File: tb/sptt_tx_tristate_tb.sv
module sptt_tx_tristate_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_tte = 1'b1;
    logic        cfg_late = 1'b0;
    logic        cfg_psp = 1'b0;
    logic        cfg_frm_slave = 1'b0;
    logic        cfg_clk_slave = 1'b0;
    logic [1:0]  cfg_mode = 2'd0;
    logic        cfg_frm_pol = 1'b1;
    logic [5:0]  cfg_wlen = 6'd8;
    logic [31:0] tx_word = '0;
    logic        tx_start = 1'b0;
    logic        bit_tick = 1'b0;
    logic        sclk_in = 1'b0;
    logic        frm_in = 1'b0;
    logic        sclk_out, frm_out, txd, txd_oe, busy;

    sptt_tx_tristate u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_tte(cfg_tte), .cfg_late(cfg_late),
        .cfg_psp(cfg_psp), .cfg_frm_slave(cfg_frm_slave), .cfg_clk_slave(cfg_clk_slave),
        .cfg_mode(cfg_mode), .cfg_frm_pol(cfg_frm_pol), .cfg_wlen(cfg_wlen),
        .tx_word(tx_word), .tx_start(tx_start), .bit_tick(bit_tick),
        .sclk_in(sclk_in), .frm_in(frm_in), .sclk_out(sclk_out), .frm_out(frm_out),
        .txd(txd), .txd_oe(txd_oe), .busy(busy)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int    vec = 0;
    int    mis = 0;
    bit    cmp_en = 0;
    bit    done = 0;
    string cur_req = "R1";
    int    tog = 0;
    logic  sclk_last = 1'b0;

    // Reference model state.
    logic        e_txd = 1'b0, e_oe_q = 1'b0, e_sclk = 1'b0, e_frm_act = 1'b0, e_busy = 1'b0;
    logic [31:0] m_word = '0;
    int          m_n = 8, m_p = 0, m_edges = 0;
    bit          m_cpha = 0, m_late = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vec++;
        if (act !== exp) begin
            mis++;
            $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the model.
    always @(negedge clk) begin
        if (rst_n && cmp_en && !done) begin
            chk({cur_req, " txd"}, txd, e_txd);
            chk({cur_req, " txd_oe"}, txd_oe, (!cfg_tte) | e_oe_q);
            chk({cur_req, " sclk_out"}, sclk_out, cfg_clk_slave ? cfg_mode[1] : e_sclk);
            chk({cur_req, " frm_out"}, frm_out,
                (!cfg_frm_slave && e_frm_act) ? cfg_frm_pol : !cfg_frm_pol);
            chk({cur_req, " busy"}, busy, e_busy);
        end
        if (sclk_out !== sclk_last) tog++;
        sclk_last = sclk_out;
    end

    function automatic int clampn(input int w);
        return (w < 4) ? 4 : ((w > 32) ? 32 : w);
    endfunction

    task automatic model_go();
        e_busy = 1; e_frm_act = 1; m_edges = 0;
        if (m_cpha) m_p = 0;
        else begin
            e_txd = m_word[m_n-1]; e_oe_q = 1; m_p = 1;
        end
    endtask

    task automatic model_edge();
        int p, two, rel, lv, en, e;
        p = m_p; two = 2 * m_n;
        rel = m_late ? two : two - 1;
        lv = m_cpha ? two - 1 : two;
        en = (rel > lv) ? rel : lv;
        e = m_cpha ? p : p - 1;
        if (p % 2 == 0 && p <= two - 2) begin
            e_txd = m_word[m_n-1-p/2];
            if (p == 0) e_oe_q = 1;
        end
        if (p == rel) e_oe_q = 0;
        if (p == two - 1) e_frm_act = 0;
        if (!cfg_clk_slave && e < two) e_sclk = ~e_sclk;
        if (p == en) e_busy = 0;
        m_p = p + 1;
        m_edges++;
    endtask

    task automatic set_cfg(input bit tte, input bit late, input bit psp, input bit fsl,
                           input bit csl, input int mode, input bit pol, input int wlen);
        @(negedge clk);
        cmp_en = 0;
        cfg_tte = tte; cfg_late = late; cfg_psp = psp; cfg_frm_slave = fsl;
        cfg_clk_slave = csl; cfg_mode = 2'(mode); cfg_frm_pol = pol; cfg_wlen = 6'(wlen);
        sclk_in = cfg_mode[1]; frm_in = !pol;
        repeat (5) @(posedge clk);
        #1 e_sclk = cfg_mode[1];
        cmp_en = 1;
    endtask

    task automatic edge1();
        @(negedge clk);
        if (!cfg_clk_slave) begin
            bit_tick = 1;
            @(posedge clk);
            #1 bit_tick = 0;
        end else begin
            sclk_in = ~sclk_in;
            repeat (3) @(posedge clk);
            #1;
        end
        model_edge();
    endtask

    task automatic send(input logic [31:0] w);
        @(negedge clk);
        tx_word = w; tx_start = 1;
        @(posedge clk);
        #1 tx_start = 0;
        m_word = w; m_n = clampn(int'(cfg_wlen)); m_cpha = cfg_mode[0];
        m_late = cfg_late & cfg_psp & cfg_frm_slave;
        tog = 0;
        if (!cfg_frm_slave) begin
            @(posedge clk);
            #1 model_go();
        end else begin
            @(negedge clk);
            frm_in = cfg_frm_pol;
            repeat (3) @(posedge clk);
            #1 model_go();
        end
    endtask

    task automatic run_word(input logic [31:0] w);
        send(w);
        for (int i = 0; i < 80 && e_busy; i++) edge1();
        @(negedge clk);
        frm_in = !cfg_frm_pol;
        repeat (4) @(posedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        mis++;
        $display("FAIL watchdog: got timeout expected completion");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, mis);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk("R1 txd", txd, 0); chk("R1 txd_oe", txd_oe, 0);
        chk("R1 sclk", sclk_out, 0); chk("R1 frm", frm_out, 0); chk("R1 busy", busy, 0);
        cmp_en = 1;

        // R3 R4 R5 R6 R7 R11: all four clock modes, clock and frame master; late ignored.
        for (int md = 0; md < 4; md++) begin
            cur_req = "R6";
            set_cfg(1, 1, 1, 0, 0, md, 1, 8);
            run_word(32'hA5 ^ 32'(md * 37));
            chk("R4 sclk transitions", tog, 16);
            chk("R7 edges used without late", m_edges, m_cpha ? 16 : 16);
        end

        // R7 R8: late release, frame slave, clock master, hidden trailing edge.
        cur_req = "R8";
        set_cfg(1, 1, 1, 1, 0, 1, 1, 12);
        run_word(32'h9C3);
        chk("R8 sclk transitions", tog, 24);
        chk("R8 edges counted", m_edges, 25);
        cur_req = "R7";
        set_cfg(1, 1, 1, 1, 0, 0, 1, 12);
        run_word(32'h5A6);
        chk("R7 sclk transitions phase0", tog, 24);

        // R7: late requested without programmable serial format is ignored.
        set_cfg(1, 1, 0, 1, 0, 1, 1, 8);
        run_word(32'hC3);
        chk("R7 no extra edge", m_edges, 16);

        // R9: clock slave waits for the extra external edge.
        cur_req = "R9";
        set_cfg(1, 1, 1, 1, 1, 3, 1, 6);
        send(32'h2D);
        for (int i = 0; i < 12; i++) edge1();
        repeat (20) @(posedge clk);
        @(negedge clk);
        chk("R9 held driven", txd_oe, 1);
        chk("R9 still busy", busy, 1);
        edge1();
        @(negedge clk);
        chk("R9 released", txd_oe, 0);
        frm_in = !cfg_frm_pol;
        repeat (4) @(posedge clk);

        // R6 R3: clock slave, normal release, both phases.
        cur_req = "R6";
        set_cfg(1, 0, 0, 0, 1, 0, 1, 8);
        run_word(32'h6E);
        set_cfg(1, 0, 0, 0, 1, 1, 1, 8);
        run_word(32'h91);

        // R10: tristate disabled; pin driven and holding last bit.
        cur_req = "R10";
        set_cfg(0, 0, 0, 0, 0, 1, 1, 8);
        run_word(32'h81);
        repeat (10) @(posedge clk);
        @(negedge clk);
        chk("R10 oe held", txd_oe, 1);
        chk("R10 last bit held", txd, 1);
        run_word(32'h7E);
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk("R10 last bit held 0", txd, 0);

        // R2: clamped word lengths and full width.
        cur_req = "R2";
        set_cfg(1, 0, 0, 0, 0, 1, 1, 2);
        run_word(32'hB);
        chk("R2 length 2 clamped to 4", tog, 8);
        set_cfg(1, 0, 0, 0, 0, 0, 1, 32);
        run_word(32'hDEADBEEF);
        chk("R2 length 32", tog, 64);
        set_cfg(1, 0, 0, 0, 0, 1, 1, 40);
        run_word(32'h80000001);
        chk("R2 length 40 clamped", tog, 64);

        // R11: active-low frame as master.
        cur_req = "R11";
        set_cfg(1, 0, 0, 0, 0, 2, 0, 5);
        run_word(32'h15);

        // R12: frame slave, active-low; a frame with no stored word starts nothing.
        cur_req = "R12";
        set_cfg(1, 1, 1, 1, 0, 1, 0, 8);
        @(negedge clk);
        frm_in = 0;
        repeat (6) @(posedge clk);
        @(negedge clk);
        chk("R12 no word no start", busy, 0);
        chk("R12 pin idle", txd_oe, 0);
        frm_in = 1;
        repeat (4) @(posedge clk);
        run_word(32'h3C);
        chk("R12 word sent late", m_edges, 17);

        repeat (5) @(posedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, mis);
        $finish;
    end

endmodule